// File: doc/BRIEF.md
# Caller Identification FSK Byte Framer

This block sits behind a 1200 baud caller-identification FSK demodulator. It turns the demodulated serial line into message bytes. The stream must first prove it is a caller-ID burst. The block looks for the alternating-bit channel-seizure preamble, and after that for the steady high mark period that follows it. Once both have been seen, the block frames asynchronous characters: a low start bit, eight data bits with the least significant bit first, and a high stop bit.

Each good character is presented on the byte output with a one-cycle valid strobe. That strobe also serves as the interrupt to the host. A character whose stop bit samples low produces a one-cycle framing-error pulse and is discarded. A host-driven enable gates the whole block. While it is low, nothing is framed and the qualification flags are cleared, so noise seen outside an expected FSK window never becomes data.

The bit timebase is a counter of `CLK_PER_BIT` system clocks per bit. The line passes through a two-flop synchroniser before any edge is detected.

Top module: `cid_fsk_framer`

## Requirements
- R1: While rst_ni is low, byte_o is 0 and byte_valid_o, frame_err_o, seizure_seen_o and mark_seen_o are all 0.
- R2: seizure_seen_o rises after SEIZE_BITS consecutive line transitions, each spaced between 0.5 and 1.5 bit periods from the previous one. It then stays set while enabled. Slower transitions do not set it.
- R3: mark_seen_o rises only after seizure_seen_o is set and the line has then stayed high for MARK_BITS bit periods. A long high period without a prior seizure leaves it 0.
- R4: After mark_seen_o is set, a character consisting of a low start bit, data bits sent least significant first, and a high stop bit is presented on byte_o with bit 0 being the first data bit received.
- R5: A character whose stop bit samples low pulses frame_err_o for one cycle. byte_valid_o does not pulse and byte_o keeps its previous value.
- R6: byte_valid_o is a single-cycle pulse per good character, and it never coincides with frame_err_o.
- R7: While enable_i is low, no byte or error is reported, byte_o is unchanged, and both flags are cleared within one cycle.
- R8: A falling edge whose line is high again at the half-bit point is rejected as a start bit. The framer then re-arms on the next falling edge.
- R9: byte_o stays stable from one valid strobe until the next.
- R10: No character is framed before mark_seen_o is set, including after enable_i has been dropped and raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Framer enable; low discards the line and clears the flags |
| rx_data_i | input | 1 | Demodulated serial data, idle high |
| byte_o | output | DATA_BITS (8) | Last good character, LSB first received |
| byte_valid_o | output | 1 | One-cycle strobe and interrupt for a new character |
| frame_err_o | output | 1 | One-cycle pulse for a character with a low stop bit |
| seizure_seen_o | output | 1 | Alternating preamble recognised |
| mark_seen_o | output | 1 | Mark period recognised after the preamble |

## Verification
The assertions assume that rx_data_i holds each bit for a whole number of clocks close to `CLK_PER_BIT`. They also assume that enable_i and rx_data_i change away from the sampling edge. The bench drives every bit for exactly `CLK_PER_BIT` cycles from the falling clock edge, so the sample points fall in the middle of each bit. The one deliberate violation is a short start glitch, and it is used only to check that the start bit is rejected. Enable changes also happen on the falling edge, so the gating of valid and of the flags is always seen one clean cycle later.

// File: rtl/cid_pkg.sv
`timescale 1ns/1ps
package cid_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_e;
endpackage

// File: rtl/cid_sync.sv
`timescale 1ns/1ps
module cid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic line_o,
  output logic fall_o,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  // reset to idle-high so no false fall after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
  assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/cid_preamble_det.sv
`timescale 1ns/1ps
module cid_preamble_det #(
  parameter int CLK_PER_BIT = 83333,
  parameter int SEIZE_BITS  = 30,
  parameter int MARK_BITS   = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  input  logic edge_i,
  output logic seize_o,
  output logic mark_o
);
  localparam int GAP_MAX  = 2 * CLK_PER_BIT;
  localparam int GW       = $clog2(GAP_MAX + 1);
  localparam int RW       = $clog2(SEIZE_BITS + 1);
  localparam int MARK_CYC = MARK_BITS * CLK_PER_BIT;
  localparam int MW       = $clog2(MARK_CYC + 1);
  localparam logic [GW-1:0] GAP_SAT  = GW'(GAP_MAX);
  localparam logic [GW-1:0] GAP_LO   = GW'(CLK_PER_BIT / 2);
  localparam logic [GW-1:0] GAP_HI   = GW'(CLK_PER_BIT + CLK_PER_BIT / 2);
  localparam logic [RW-1:0] RUN_LAST = RW'(SEIZE_BITS - 1);
  localparam logic [RW-1:0] RUN_SAT  = RW'(SEIZE_BITS);
  localparam logic [MW-1:0] MARK_LAST = MW'(MARK_CYC - 1);

  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic [MW-1:0] high_q;
  logic          in_win;

  assign in_win = (gap_q >= GAP_LO) && (gap_q <= GAP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= GAP_SAT;
      run_q   <= '0;
      seize_o <= 1'b0;
    end else if (!en_i) begin
      gap_q   <= GAP_SAT;
      run_q   <= '0;
      seize_o <= 1'b0;
    end else if (edge_i) begin
      gap_q <= '0;
      if (in_win) begin
        if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
        if (run_q >= RUN_LAST) seize_o <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end else if (gap_q != GAP_SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // mark: steady high, counted only once the preamble is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_q <= '0;
      mark_o <= 1'b0;
    end else if (!en_i) begin
      high_q <= '0;
      mark_o <= 1'b0;
    end else if (!line_i || !seize_o) begin
      high_q <= '0;
    end else if (high_q != MARK_LAST) begin
      high_q <= high_q + 1'b1;
    end else begin
      mark_o <= 1'b1;
    end
  end

  a_r3_mark_needs_seize: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> seize_o);
  a_r7_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!seize_o && !mark_o));
  a_r2_seize_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seize_o && en_i) |=> seize_o);
endmodule

// File: rtl/cid_framer.sv
`timescale 1ns/1ps
module cid_framer
  import cid_pkg::*;
#(
  parameter int CLK_PER_BIT = 83333,
  parameter int DATA_BITS   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 arm_i,
  input  logic                 line_i,
  input  logic                 fall_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 valid_o,
  output logic                 ferr_o
);
  localparam int CW = $clog2(CLK_PER_BIT);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(CLK_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

  fr_state_e             state_q;
  logic [CW-1:0]         cnt_q;
  logic [IW-1:0]         idx_q;
  logic [DATA_BITS-1:0]  shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (!en_i) begin
        state_q <= FR_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          FR_IDLE: if (arm_i && fall_i) begin
            state_q <= FR_START;
            cnt_q   <= '0;
          end
          FR_START: if (cnt_q == HALF_LAST) begin
            // mid start bit: must still be low
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= line_i ? FR_IDLE : FR_DATA;
          end else cnt_q <= cnt_q + 1'b1;
          FR_DATA: if (cnt_q == FULL_LAST) begin
            cnt_q   <= '0;
            shreg_q <= {line_i, shreg_q[DATA_BITS-1:1]};
            if (idx_q == IDX_LAST) state_q <= FR_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          FR_STOP: if (cnt_q == FULL_LAST) begin
            cnt_q   <= '0;
            state_q <= FR_IDLE;
            if (line_i) begin
              byte_o  <= shreg_q;
              valid_o <= 1'b1;
            end else begin
              ferr_o  <= 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= FR_IDLE;
        endcase
      end
    end
  end

  a_r6_valid_ferr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && ferr_o));
  a_r6_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r7_no_byte_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || ferr_o) |-> $past(en_i));
  a_r9_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(byte_o));
endmodule

// File: rtl/cid_fsk_framer.sv
`timescale 1ns/1ps
module cid_fsk_framer #(
  parameter int CLK_PER_BIT = 83333,
  parameter int SEIZE_BITS  = 30,
  parameter int MARK_BITS   = 80,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic                 rx_data_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_valid_o,
  output logic                 frame_err_o,
  output logic                 seizure_seen_o,
  output logic                 mark_seen_o
);
  logic line, fall, edge_any;

  cid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_data_i),
    .line_o (line),
    .fall_o (fall),
    .edge_o (edge_any)
  );

  cid_preamble_det #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .SEIZE_BITS  (SEIZE_BITS),
    .MARK_BITS   (MARK_BITS)
  ) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .line_i  (line),
    .edge_i  (edge_any),
    .seize_o (seizure_seen_o),
    .mark_o  (mark_seen_o)
  );

  cid_framer #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .DATA_BITS   (DATA_BITS)
  ) u_fr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .arm_i   (mark_seen_o),
    .line_i  (line),
    .fall_i  (fall),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o),
    .ferr_o  (frame_err_o)
  );

  a_r10_valid_needs_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(mark_seen_o));
endmodule

// File: tb/cid_fsk_framer_tb.sv
`timescale 1ns/1ps
module cid_fsk_framer_tb;
  localparam int CPB = 16;
  localparam int NV  = 6;
  // {stop_ok, data}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'h3C}, {1'b1, 8'h81}, {1'b0, 8'hC3}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0;
  logic rx_data_i = 1'b1;
  logic [7:0] byte_o;
  logic byte_valid_o, frame_err_o, seizure_seen_o, mark_seen_o;

  int n_chk = 0, n_bad = 0, n_valid = 0, n_ferr = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  cid_fsk_framer #(.CLK_PER_BIT(CPB), .SEIZE_BITS(8), .MARK_BITS(10)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .rx_data_i(rx_data_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .frame_err_o(frame_err_o),
    .seizure_seen_o(seizure_seen_o), .mark_seen_o(mark_seen_o)
  );

  always @(negedge clk_i) begin
    if (byte_valid_o) n_valid++;
    if (frame_err_o)  n_ferr++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_data_i = b;
    repeat (CPB) @(negedge clk_i);
  endtask

  task automatic send_char(input logic [7:0] d, input logic stop_ok);
    send_bit(1'b0);
    for (int k = 0; k < 8; k++) send_bit(d[k]);
    send_bit(stop_ok);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  initial begin
    int v0, f0;
    logic [7:0] last;
    @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 byte", byte_o, 0);
    check("R1 flags", {byte_valid_o, frame_err_o, seizure_seen_o, mark_seen_o}, 0);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    repeat (2) @(negedge clk_i);

    // R3: long high with no preamble
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    check("R3 no mark without seizure", mark_seen_o, 0);
    // R10: character before qualification
    send_char(8'h0F, 1'b1);
    check("R10 no byte before mark", n_valid, 0);
    check("R2 slow edges no seizure", seizure_seen_o, 0);

    // R2 seizure preamble
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    check("R2 seizure seen", seizure_seen_o, 1);
    check("R3 mark not yet", mark_seen_o, 0);
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    check("R3 mark seen", mark_seen_o, 1);

    // R4/R5/R6/R9 vector walk
    last = 8'h00;
    for (int i = 0; i < NV; i++) begin
      v0 = n_valid; f0 = n_ferr;
      send_char(VEC[i][7:0], VEC[i][8]);
      if (VEC[i][8]) begin
        check("R6 one valid", n_valid - v0, 1);
        check("R4 byte", byte_o, VEC[i][7:0]);
        check("R6 no ferr", n_ferr - f0, 0);
        last = VEC[i][7:0];
      end else begin
        check("R5 ferr", n_ferr - f0, 1);
        check("R5 no valid", n_valid - v0, 0);
        check("R5 byte kept", byte_o, last);
      end
    end

    // R8 short start glitch
    v0 = n_valid; f0 = n_ferr;
    rx_data_i = 1'b0;
    repeat (CPB / 4) @(negedge clk_i);
    rx_data_i = 1'b1;
    repeat (3 * CPB) @(negedge clk_i);
    check("R8 glitch no byte", n_valid - v0, 0);
    check("R8 glitch no ferr", n_ferr - f0, 0);
    send_char(8'h5A, 1'b1);
    check("R8 rearm byte", byte_o, 8'h5A);

    // R9 hold
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check("R9 byte held", byte_o, 8'h5A);

    // R7 disable
    enable_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R7 flags cleared", {seizure_seen_o, mark_seen_o}, 0);
    v0 = n_valid; f0 = n_ferr;
    send_char(8'h33, 1'b1);
    send_char(8'h44, 1'b0);
    check("R7 no byte off", n_valid - v0, 0);
    check("R7 no ferr off", n_ferr - f0, 0);
    check("R7 byte unchanged", byte_o, 8'h5A);

    // R10 re-enable needs requalification
    enable_i = 1'b1;
    repeat (2) @(negedge clk_i);
    send_char(8'h77, 1'b1);
    check("R10 no byte after reenable", n_valid - v0, 0);
    check("R10 byte unchanged", byte_o, 8'h5A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hang exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule